// File: doc/BRIEF.md
# Serial Programming Target Receiver

This block is the target side of the serial programming port of a small microcontroller. While an external pin holds the device in programming mode, a programmer drives a serial clock and data line. The block returns data on a third line. Every instruction is a frame of exactly four bytes. The serial clock and data are oversampled and synchronised into the system clock domain. The block assembles the frames and decodes them. A valid enable frame must arrive before any other frame is acted on.

Two page buffers are held inside the block. The first is word-organised and stores program data one byte half at a time. The second is byte-organised and stores EEPROM data, and each of its bytes has a loaded flag. A page commit walks the selected buffer and sends a stream of write strobes, each carrying the full address, to a behavioural memory model. A single-byte EEPROM write sends one write strobe. After every write instruction, a busy flag stays high for a configurable time. A programmer can poll this flag with a status instruction.

Top module: `sprog_target`

## Requirements
- R1: MOSI is sampled when SCK rises. MISO changes only after a falling SCK edge, or when programming mode is left. Each byte is sent most significant bit first.
- R2: Bytes are grouped into frames of four. The bit and byte position both return to zero while `target_held` is low, so a partial byte sent before programming mode is left is discarded.
- R3: A frame whose first byte is 0xAC and second byte is 0x53 sets the enabled state. Any value is accepted in the last two bytes. The enabled state is cleared while `target_held` is low.
- R4: During the third byte of every frame, MISO returns the second byte of the same frame.
- R5: While the block is not enabled, every frame except the enable frame is ignored. No memory write occurs, and the fourth-byte poll answer is 0x00.
- R6: First byte 0x40 loads the low byte, and 0x48 loads the high byte, of the program buffer word selected by bits [5:0] of the third byte. The data is the fourth byte.
- R7: First byte 0x4C takes address A = {byte2[4:0], byte3} and commits the program buffer to page A[12:6]. The block then emits 64 writes at addresses page*64+0 through page*64+63, in increasing order, with data {high, low}. The buffer keeps its contents after the commit.
- R8: First byte 0xC1 loads EEPROM buffer byte byte3[5:0] with the fourth byte. First byte 0xC2 commits to page A[12:6], with A formed as in R7. The commit writes only the bytes loaded since the last EEPROM commit and then clears every loaded flag.
- R9: First byte 0xC0 writes the fourth byte to EEPROM address A, with A formed as in R7, and replaces whatever the location held. The upper data byte is 0.
- R10: `busy` goes high after each accepted write instruction (0x4C, 0xC2, 0xC0). It stays high for max(BUSY_CYCLES, 2^IDX_W+3) cycles and covers every write strobe. First byte 0xF0 makes the fourth byte on MISO {7'b0, busy}.
- R11: Load and write instructions that arrive while `busy` is high are ignored.
- R12: Out of reset, `miso`, `busy` and `mem_we` are 0. MISO returns 0x00 in the first, second and fourth bytes of every frame except the fourth byte of a poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| target_held | input | 1 | High while the device is held in programming mode |
| sck | input | 1 | Serial clock from the programmer, asynchronous |
| mosi | input | 1 | Serial data from the programmer |
| miso | output | 1 | Serial data to the programmer |
| mem_we | output | 1 | Memory model write strobe |
| mem_eeprom | output | 1 | 1 selects the EEPROM array, 0 the program array |
| mem_addr | output | ADDR_W | Word (program) or byte (EEPROM) address |
| mem_wdata | output | 16 | Write data; upper byte 0 for EEPROM |
| busy | output | 1 | Write in progress |

## Verification
If the byte position drifts, the fault shows in the next frame. The echo moves off the third byte, or a load lands on the wrong word. The write-strobe count and data expose it once the next commit finishes. A stale loaded flag makes a later EEPROM commit emit writes that should not exist. A busy timer that runs wrong shows either as a poll answer that disagrees with the time since the commit, or as a write that is silently dropped within one frame after a commit. An enabled state that survives leaving programming mode lets a write through before a new enable frame, which is visible as an unexpected strobe a few cycles after that frame.

// File: rtl/sprog_pkg.sv
package sprog_pkg;
  localparam logic [7:0] OP_ENABLE  = 8'hAC;
  localparam logic [7:0] KEY_ENABLE = 8'h53;
  localparam logic [7:0] OP_LD_PLO  = 8'h40;
  localparam logic [7:0] OP_LD_PHI  = 8'h48;
  localparam logic [7:0] OP_WR_PAGE = 8'h4C;
  localparam logic [7:0] OP_LD_EE   = 8'hC1;
  localparam logic [7:0] OP_WR_EEPG = 8'hC2;
  localparam logic [7:0] OP_WR_EEB  = 8'hC0;
  localparam logic [7:0] OP_POLL    = 8'hF0;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_LD_PROG,
    REQ_WR_PROG,
    REQ_LD_EE,
    REQ_WR_EE,
    REQ_WR_BYTE
  } req_e;
endpackage

// File: rtl/sprog_link.sv
module sprog_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_byte,
  output logic       miso,
  output logic       sck_fall,
  output logic       byte_vld,
  output logic [7:0] byte_data,
  output logic [1:0] byte_idx
);
  logic [2:0] sck_sh;
  logic [1:0] mosi_sh;
  logic       sck_rise;
  logic       mosi_s;
  logic [2:0] bit_cnt;
  logic [1:0] frame_pos;
  logic [6:0] rx_sr;
  logic [7:0] tx_sr;

  // two-stage synchronisers; the third sck stage feeds edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh  <= '0;
      mosi_sh <= '0;
    end else begin
      sck_sh  <= {sck_sh[1:0], sck};
      mosi_sh <= {mosi_sh[0], mosi};
    end
  end

  assign sck_rise = sck_sh[1] & ~sck_sh[2];
  assign sck_fall = ~sck_sh[1] & sck_sh[2];
  assign mosi_s   = mosi_sh[1];

  always_ff @(posedge clk) begin
    if (rst || !hold) begin
      bit_cnt   <= '0;
      frame_pos <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      miso      <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_idx  <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (sck_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld  <= 1'b1;
          byte_data <= {rx_sr, mosi_s};
          byte_idx  <= frame_pos;
          frame_pos <= frame_pos + 2'd1;
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          miso  <= tx_byte[7];
          tx_sr <= {tx_byte[6:0], 1'b0};
        end else begin
          miso  <= tx_sr[7];
          tx_sr <= {tx_sr[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sprog_decode.sv
module sprog_decode
  import sprog_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 6,
  localparam int PAGE_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  input  logic [1:0]        byte_idx,
  input  logic              busy,
  output logic [7:0]        tx_byte,
  output logic              enabled,
  output req_e              req,
  output logic [IDX_W-1:0]  req_idx,
  output logic              req_hi,
  output logic [PAGE_W-1:0] req_page,
  output logic [ADDR_W-1:0] req_addr,
  output logic [7:0]        req_data
);
  logic [7:0]  b0, b1, b2;
  logic [15:0] addr_pair;
  req_e        cmd;

  assign addr_pair = {b1, b2};

  always_comb begin
    cmd = REQ_NONE;
    unique case (b0)
      OP_LD_PLO, OP_LD_PHI: cmd = REQ_LD_PROG;
      OP_WR_PAGE:           cmd = REQ_WR_PROG;
      OP_LD_EE:             cmd = REQ_LD_EE;
      OP_WR_EEPG:           cmd = REQ_WR_EE;
      OP_WR_EEB:            cmd = REQ_WR_BYTE;
      default:              cmd = REQ_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      b0       <= '0;
      b1       <= '0;
      b2       <= '0;
      tx_byte  <= '0;
      enabled  <= 1'b0;
      req      <= REQ_NONE;
      req_idx  <= '0;
      req_hi   <= 1'b0;
      req_page <= '0;
      req_addr <= '0;
      req_data <= '0;
    end else begin
      req <= REQ_NONE;
      if (!hold) begin
        enabled <= 1'b0;
        tx_byte <= '0;
      end else if (byte_vld) begin
        unique case (byte_idx)
          2'd0: begin
            b0      <= byte_data;
            tx_byte <= '0;
          end
          2'd1: begin
            b1      <= byte_data;
            tx_byte <= byte_data;
          end
          2'd2: begin
            b2      <= byte_data;
            tx_byte <= (enabled && b0 == OP_POLL) ? {7'b0, busy} : 8'h00;
          end
          default: begin
            tx_byte  <= '0;
            req_idx  <= b2[IDX_W-1:0];
            req_hi   <= (b0 == OP_LD_PHI);
            req_page <= PAGE_W'(addr_pair >> IDX_W);
            req_addr <= ADDR_W'(addr_pair);
            req_data <= byte_data;
            if (b0 == OP_ENABLE && b1 == KEY_ENABLE)
              enabled <= 1'b1;
            else if (enabled && !busy)
              req <= cmd;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sprog_pagebuf.sv
module sprog_pagebuf
  import sprog_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int IDX_W       = 6,
  parameter int BUSY_CYCLES = 200,
  localparam int PAGE_W   = ADDR_W - IDX_W,
  localparam int DEPTH    = 1 << IDX_W,
  localparam int WALK_CYC = DEPTH + 3,
  localparam int HOLD     = (BUSY_CYCLES > WALK_CYC) ? BUSY_CYCLES : WALK_CYC,
  localparam int CNT_W    = $clog2(HOLD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  req_e              req,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic              req_hi,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  output logic              mem_we,
  output logic              mem_eeprom,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              busy
);
  localparam int NBANK = 3; // 0: program low, 1: program high, 2: EEPROM

  logic [NBANK-1:0]   bank_we;
  logic [NBANK*8-1:0] rd_bus;
  logic [IDX_W-1:0]   rd_idx;
  logic [DEPTH-1:0]   ee_loaded;
  logic               walking, walk_ee;
  logic [PAGE_W-1:0]  walk_page;
  logic               p1_vld, p1_flag;
  logic [IDX_W-1:0]   p1_idx;
  logic [CNT_W-1:0]   busy_cnt;
  logic               start;

  assign bank_we[0] = (req == REQ_LD_PROG) && !req_hi;
  assign bank_we[1] = (req == REQ_LD_PROG) && req_hi;
  assign bank_we[2] = (req == REQ_LD_EE);
  assign start = (req == REQ_WR_PROG) || (req == REQ_WR_EE) || (req == REQ_WR_BYTE);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (bank_we[g]) mem[req_idx] <= req_data;
      q <= mem[rd_idx];
    end
    assign rd_bus[g*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ee_loaded  <= '0;
      walking    <= 1'b0;
      walk_ee    <= 1'b0;
      walk_page  <= '0;
      rd_idx     <= '0;
      p1_vld     <= 1'b0;
      p1_flag    <= 1'b0;
      p1_idx     <= '0;
      mem_we     <= 1'b0;
      mem_eeprom <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
    end else begin
      p1_vld <= 1'b0;
      mem_we <= 1'b0;
      if (bank_we[2]) ee_loaded[req_idx] <= 1'b1;
      if (req == REQ_WR_PROG || req == REQ_WR_EE) begin
        walking   <= 1'b1;
        walk_ee   <= (req == REQ_WR_EE);
        walk_page <= req_page;
        rd_idx    <= '0;
      end else if (walking) begin
        p1_vld  <= 1'b1;
        p1_idx  <= rd_idx;
        p1_flag <= ee_loaded[rd_idx];
        rd_idx  <= rd_idx + 1'b1;
        if (&rd_idx) begin
          walking <= 1'b0;
          if (walk_ee) ee_loaded <= '0;
        end
      end
      if (p1_vld && (!walk_ee || p1_flag)) begin
        mem_we     <= 1'b1;
        mem_eeprom <= walk_ee;
        mem_addr   <= {walk_page, p1_idx};
        mem_wdata  <= walk_ee ? {8'h00, rd_bus[23:16]} : {rd_bus[15:8], rd_bus[7:0]};
      end else if (req == REQ_WR_BYTE) begin
        mem_we     <= 1'b1;
        mem_eeprom <= 1'b1;
        mem_addr   <= req_addr;
        mem_wdata  <= {8'h00, req_data};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      busy     <= 1'b0;
    end else if (start) begin
      busy_cnt <= CNT_W'(HOLD);
      busy     <= 1'b1;
    end else if (busy_cnt != '0) begin
      busy_cnt <= busy_cnt - 1'b1;
      busy     <= (busy_cnt != CNT_W'(1));
    end
  end
endmodule

// File: rtl/sprog_target.sv
module sprog_target
  import sprog_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int IDX_W       = 6,
  parameter int BUSY_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              target_held,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              mem_we,
  output logic              mem_eeprom,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic              busy
);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic              sck_fall, byte_vld, enabled, req_hi;
  logic [7:0]        byte_data, tx_byte, req_data;
  logic [1:0]        byte_idx;
  req_e              req;
  logic [IDX_W-1:0]  req_idx;
  logic [PAGE_W-1:0] req_page;
  logic [ADDR_W-1:0] req_addr;

  sprog_link i_link (
    .clk(clk), .rst(rst), .hold(target_held), .sck(sck), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .sck_fall(sck_fall),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_idx(byte_idx)
  );

  sprog_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_decode (
    .clk(clk), .rst(rst), .hold(target_held), .byte_vld(byte_vld),
    .byte_data(byte_data), .byte_idx(byte_idx), .busy(busy),
    .tx_byte(tx_byte), .enabled(enabled), .req(req), .req_idx(req_idx),
    .req_hi(req_hi), .req_page(req_page), .req_addr(req_addr), .req_data(req_data)
  );

  sprog_pagebuf #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) i_pagebuf (
    .clk(clk), .rst(rst), .req(req), .req_idx(req_idx), .req_hi(req_hi),
    .req_page(req_page), .req_addr(req_addr), .req_data(req_data),
    .mem_we(mem_we), .mem_eeprom(mem_eeprom), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy)
  );
endmodule

// File: rtl/sprog_checker.sv
module sprog_checker
  import sprog_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       target_held,
  input logic       miso,
  input logic       sck_fall,
  input logic       byte_vld,
  input logic [1:0] byte_idx,
  input logic       enabled,
  input req_e       req,
  input logic       busy,
  input logic       mem_we
);
  logic [1:0] exp_pos;

  always_ff @(posedge clk) begin
    if (rst || !target_held) exp_pos <= '0;
    else if (byte_vld)       exp_pos <= exp_pos + 2'd1;
  end

  AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> ($past(sck_fall) || !$past(target_held))); // R1
  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
    byte_vld |-> (byte_idx == exp_pos)); // R2
  AST_BYTE_PULSE: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> !byte_vld); // R2
  AST_ENABLE_DROP: assert property (@(posedge clk) disable iff (rst)
    !target_held |=> !enabled); // R3
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (req != REQ_NONE) |-> enabled); // R5
  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R10
  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req != REQ_NONE) |-> !busy); // R11
endmodule

bind sprog_target sprog_checker i_chk (
  .clk(clk), .rst(rst), .target_held(target_held), .miso(miso),
  .sck_fall(sck_fall), .byte_vld(byte_vld), .byte_idx(byte_idx),
  .enabled(enabled), .req(req), .busy(busy), .mem_we(mem_we)
);

// File: tb/test_sprog_target.sv
module test_sprog_target;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int BUSY = 500;
  localparam int NVEC = 10;
  // {byte0..byte3, expected MISO in byte 3, expected MISO in byte 4}
  localparam logic [47:0] VEC [NVEC] = '{
    48'hF0112233_1100, 48'hAC530000_5300, 48'h400005A1_0000, 48'h480005B2_0000,
    48'h40003FC3_0000, 48'h48003FD4_0000, 48'hC10002E5_0000, 48'hC1003EF6_0000,
    48'hF0000000_0000, 48'hAC123456_1200
  };

  logic clk = 1'b0, rst = 1'b1, held = 1'b0, sck = 1'b0, mosi = 1'b0;
  logic miso, mem_we, mem_eeprom, busy;
  logic [12:0] mem_addr;
  logic [15:0] mem_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprog_target #(.BUSY_CYCLES(BUSY)) i_sprog_target (
    .clk(clk), .rst(rst), .target_held(held), .sck(sck), .mosi(mosi),
    .miso(miso), .mem_we(mem_we), .mem_eeprom(mem_eeprom),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  int nchk = 0, nerr = 0, pwr = 0, ewr = 0, first_p = -1, last_p = -1;
  logic [15:0] pmem [int];
  logic [7:0]  emem [int];

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (mem_eeprom) begin
        emem[int'(mem_addr)] = mem_wdata[7:0];
        ewr++;
      end else begin
        pmem[int'(mem_addr)] = mem_wdata;
        if (first_p < 0) first_p = int'(mem_addr);
        last_p = int'(mem_addr);
        pwr++;
      end
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] f, output logic [31:0] r);
    logic [7:0] rb;
    for (int k = 3; k >= 0; k--) begin
      xfer(f[k*8 +: 8], rb);
      r[k*8 +: 8] = rb;
    end
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic wait_idle;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (5) @(negedge clk);
    chk("R12 reset miso", miso, 0);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset mem_we", mem_we, 0);
    rst = 1'b0;
    held = 1'b1;
    repeat (5) @(negedge clk);

    // R5: nothing acts before enable
    frame(32'h4C014000, r);
    frame(32'hC0001099, r);
    repeat (600) @(negedge clk);
    chk("R5 no prog writes", pwr, 0);
    chk("R5 no ee writes", ewr, 0);
    chk("R5 not busy", busy, 0);

    for (int i = 0; i < NVEC; i++) begin
      frame(VEC[i][47:16], r);
      chk("R1 R4 echo", r[15:8], VEC[i][15:8]);
      chk("R12 R10 byte4", r[7:0], VEC[i][7:0]);
      chk("R12 byte2", r[23:16], 0);
      chk("R12 byte1", r[31:24], 0);
    end

    // R7 R6 R10: program commit to page 5
    frame(32'h4C014000, r);
    chk("R10 busy after commit", busy, 1);
    frame(32'hF0000000, r);
    chk("R10 poll busy", r[7:0], 8'h01);
    frame(32'hF0000000, r);
    chk("R10 poll idle", r[7:0], 8'h00);
    wait_idle();
    chk("R7 write count", pwr, 64);
    chk("R7 first addr", first_p, 320);
    chk("R7 last addr", last_p, 383);
    chk("R6 word5", pmem[325], 16'hB2A1);
    chk("R6 word63", pmem[383], 16'hD4C3);

    // R11: byte write during busy is dropped
    frame(32'h4C018000, r);
    frame(32'hC0001077, r);
    wait_idle();
    chk("R11 dropped write", ewr, 0);
    chk("R7 second page count", pwr, 128);
    chk("R7 buffer kept", pmem[389], 16'hB2A1);

    // R8: EEPROM page commits
    frame(32'hC2004000, r);
    wait_idle();
    chk("R8 loaded only", ewr, 2);
    chk("R8 byte2", emem[66], 8'hE5);
    chk("R8 byte62", emem[126], 8'hF6);
    frame(32'hC2008000, r);
    wait_idle();
    chk("R8 flags cleared", ewr, 2);

    // R9: byte writes replace content
    frame(32'hC0001077, r);
    wait_idle();
    chk("R9 byte write", emem[16], 8'h77);
    frame(32'hC000100F, r);
    wait_idle();
    chk("R9 replaced", emem[16], 8'h0F);
    chk("R9 count", ewr, 4);

    // R2 R3: partial byte, leave programming mode, re-enter
    mosi = 1'b1;
    for (int i = 0; i < 3; i++) begin
      repeat (HALF) @(negedge clk);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    held = 1'b0;
    repeat (10) @(negedge clk);
    chk("R12 miso idle", miso, 0);
    held = 1'b1;
    repeat (5) @(negedge clk);
    frame(32'hF0AB0000, r);
    chk("R2 realigned echo", r[15:8], 8'hAB);
    chk("R5 poll disabled", r[7:0], 8'h00);
    frame(32'hC0002055, r);
    repeat (600) @(negedge clk);
    chk("R3 enable cleared", emem.exists(32), 0);
    frame(32'hAC530000, r);
    frame(32'hC0002055, r);
    wait_idle();
    chk("R3 re-enabled write", emem[32], 8'h55);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule